// File: doc/BRIEF.md
# Set/Clear GPIO Bank

This block is a bank of up to sixteen bidirectional general-purpose lines behind a small 16-bit register bus. Each line has an output-data bit and an output-enable bit. Software changes them only through separate write-one-to-set and write-one-to-clear offsets. No read-modify-write sequence is needed, and two agents touching different lines never race.

Pad inputs are resynchronized through a two-flop chain. The synchronized levels serve two purposes: they are handed out on a dedicated vector for a downstream interrupt detector, and they are returned on a read of the level offset. A line whose output enable is set reads back the level it drives. A line whose output enable is clear reads back its synchronized pad input.

The pad tristate is left to the chip edge. The bank provides separate enable, drive and input vectors.

Top module: `gpio_setclr_bank`

## Requirements
- R1: While reset is high and after it falls, every output-enable bit is 0, every output-data bit is 0, the read data is 0 and the level vector is 0.
- R2: A write to byte offset 0x00 sets each output-data bit whose write-data bit is 1, and leaves the bits written as 0 unchanged. The new value appears on the data pins right after the clock edge that takes the write.
- R3: A write to offset 0x04 clears each output-data bit written as 1 and leaves the other bits unchanged.
- R4: A write to offset 0x02 sets each output-enable bit written as 1 and leaves the other bits unchanged.
- R5: A write to offset 0x06 clears each output-enable bit written as 1 and leaves the other bits unchanged.
- R6: The level vector equals the pad input vector delayed by exactly two clock edges.
- R7: A read of offset 0x00 returns, one edge later, a value in which bit i is the output-data bit when output enable i is 1, and the synchronized input i otherwise. The read data holds when no read is issued.
- R8: A write to any other offset (for example 0x08) changes neither data nor enable. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 16 | Write data, one bit per line |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Levels seen at the pads |
| pad_out | output | 16 | Levels driven onto the pads |
| pad_oe | output | 16 | Per-line drive enable, 1 = output |
| line_level | output | 16 | Synchronized input levels for interrupt detection |

## Verification
On every cycle, the assertions check the following: the effect of each set and clear write on the data and enable registers, the stability of both registers when no mapped write occurs, the per-stage delay of the synchronizer, the composition of the read word, and the zero return of unmapped reads. Some behaviour only the bench scenarios can show. These are the end-to-end latency of a pad change through to a read, the readback of driven levels while the pads show the opposite value, and the accumulated register state across sequences of mixed set and clear writes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Byte offsets of the register bus; the decode depends on these values.
  localparam int unsigned OFS_LEVEL_DSET = 'h0;  // write: set data, read: pin levels
  localparam int unsigned OFS_OE_SET     = 'h2;
  localparam int unsigned OFS_DATA_CLR   = 'h4;
  localparam int unsigned OFS_OE_CLR     = 'h6;

  typedef struct packed {
    logic set;
    logic clr;
  } setclr_t;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  gpio_bank_pkg::setclr_t op,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (op.set) q <= q | bits;
    else if (op.clr) q <= q & ~bits;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
    // R6: each later stage carries the previous stage one edge on
    p_stage_shift_r6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> stg[s] == $past(stg[s-1]));
  end

  // R6: first stage captures the pad levels
  p_first_stage_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stg[0] == $past(din));

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback #(
  parameter int unsigned W      = 16,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      drv,
  input  logic [W-1:0]      oe,
  input  logic [W-1:0]      lvl,
  output logic [BUS_W-1:0]  rdata
);
  import gpio_bank_pkg::*;

  logic             hit_level;
  logic [BUS_W-1:0] word;

  assign hit_level = (addr == ADDR_W'(OFS_LEVEL_DSET));

  always_comb begin
    word = '0;
    for (int i = 0; i < W; i++) word[i] = oe[i] ? drv[i] : lvl[i];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= hit_level ? word : '0;
  end

  // R7: a level read returns the driven value on outputs, the input elsewhere
  p_level_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd && hit_level) |=> (rdata[W-1:0] & $past(oe)) == ($past(drv) & $past(oe))
                       && (rdata[W-1:0] & ~$past(oe)) == ($past(lvl) & ~$past(oe)));
  // R7: read data holds without a read
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  // R8: unmapped reads return zero
  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd && !hit_level) |=> rdata == '0);
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic [LINES-1:0]  line_level
);
  import gpio_bank_pkg::*;

  initial assert (LINES >= 1 && LINES <= BUS_W && SYNC_N >= 1);

  setclr_t          data_op, oe_op;
  logic [LINES-1:0] wbits;

  assign wbits       = bus_wdata[LINES-1:0];
  assign data_op.set = bus_wr && (bus_addr == ADDR_W'(OFS_LEVEL_DSET));
  assign data_op.clr = bus_wr && (bus_addr == ADDR_W'(OFS_DATA_CLR));
  assign oe_op.set   = bus_wr && (bus_addr == ADDR_W'(OFS_OE_SET));
  assign oe_op.clr   = bus_wr && (bus_addr == ADDR_W'(OFS_OE_CLR));

  gpio_setclr_reg #(.W(LINES)) i_data (
    .clk(clk), .rst(rst), .op(data_op), .bits(wbits), .q(pad_out));

  gpio_setclr_reg #(.W(LINES)) i_oe (
    .clk(clk), .rst(rst), .op(oe_op), .bits(wbits), .q(pad_oe));

  gpio_sync #(.W(LINES), .STAGES(SYNC_N)) i_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(line_level));

  gpio_readback #(.W(LINES), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_rb (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .drv(pad_out), .oe(pad_oe), .lvl(line_level), .rdata(bus_rdata));

  // R1: reset leaves every line an undriven input
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> pad_oe == '0 && pad_out == '0 && bus_rdata == '0);
  // R2: data set raises written ones, keeps the rest
  p_data_set_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_LEVEL_DSET)) |=>
      pad_out == ($past(pad_out) | $past(wbits)) && $stable(pad_oe));
  // R3: data clear drops written ones, keeps the rest
  p_data_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_DATA_CLR)) |=>
      pad_out == ($past(pad_out) & ~$past(wbits)) && $stable(pad_oe));
  // R4: enable set
  p_oe_set_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_OE_SET)) |=>
      pad_oe == ($past(pad_oe) | $past(wbits)) && $stable(pad_out));
  // R5: enable clear
  p_oe_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_OE_CLR)) |=>
      pad_oe == ($past(pad_oe) & ~$past(wbits)) && $stable(pad_out));
  // R8: no mapped write, no change
  p_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    !(data_op.set || data_op.clr || oe_op.set || oe_op.clr) |=>
      $stable(pad_out) && $stable(pad_oe));
endmodule

// File: tb/test_gpio_setclr_bank.sv
module test_gpio_setclr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, pad_in = '0;
  logic [15:0] bus_rdata, pad_out, pad_oe, line_level;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_out = '0, m_oe = '0;  // bench model of data and enable
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_setclr_bank i_gpio_setclr_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .line_level(line_level));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issues a read and queues the expected word for the monitor
  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] level_word();
    return (m_out & m_oe) | (pad_in & ~m_oe);
  endfunction

  // monitor
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) check("R7 unexpected read", bus_rdata, 16'hxxxx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pad_oe, 16'h0000);
    check("R1 out in reset", pad_out, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 16'h0000);
    check("R1 level after reset", line_level, 16'h0000);

    wr(4'h0, 16'h00F0); m_out = 16'h00F0;
    check("R2 set data", pad_out, m_out);
    wr(4'h0, 16'h0003); m_out = 16'h00F3;
    check("R2 zeros keep data", pad_out, m_out);
    wr(4'h4, 16'h0011); m_out = 16'h00E2;
    check("R3 clear data", pad_out, m_out);
    check("R3 oe untouched", pad_oe, 16'h0000);
    wr(4'h2, 16'hFF00); m_oe = 16'hFF00;
    check("R4 set oe", pad_oe, m_oe);
    wr(4'h6, 16'h0F00); m_oe = 16'hF000;
    check("R5 clear oe", pad_oe, m_oe);
    check("R5 data untouched", pad_out, m_out);
    wr(4'h8, 16'hFFFF);
    check("R8 unmapped write data", pad_out, m_out);
    check("R8 unmapped write oe", pad_oe, m_oe);

    // R6: two-edge synchronizer latency
    @(negedge clk); pad_in = 16'hA5C3;
    @(negedge clk); check("R6 level after one edge", line_level, 16'h0000);
    @(negedge clk); check("R6 level after two edges", line_level, 16'hA5C3);

    rd(4'h0, level_word(), "R7 level read mixed");
    rd(4'h2, 16'h0000, "R8 unmapped read");
    wr(4'h2, 16'hFFFF); m_oe = 16'hFFFF;
    wr(4'h0, 16'h8001); m_out = 16'h80E3;
    @(negedge clk); pad_in = ~m_out;
    repeat (2) @(negedge clk);
    rd(4'h0, m_out, "R7 driven lines read own level");
    wr(4'h6, 16'hFFFF); m_oe = 16'h0000;
    rd(4'h0, pad_in, "R7 inputs read pads");
    @(negedge clk); pad_in = 16'h1234;
    repeat (2) @(negedge clk);
    rd(4'h0, 16'h1234, "R7 new pad pattern");
    repeat (2) @(negedge clk);
    check("R7 rdata holds", bus_rdata, 16'h1234);
    check("R7 queue drained", 16'(exp_q.size()), 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule